// File: doc/BRIEF.md
# ADC Sample Frame Builder

This block sits between the deserialized outputs of a multi-channel ADC and a 16:1 high-speed serializer. Once per sampling period a frame strobe marks the instant at which one sample from every active channel is present on the lane bus. On that clock edge the block captures the samples and the configuration. It packs them behind an 8-bit header into a fixed 128-bit frame, zero-fills the unused space and places an 8-bit CRC in the last byte. It then streams the frame as eight 16-bit words, one per clock, starting on the very next cycle.

Two configuration bits select the sample width (12 or 14 bits) and the number of active channels (4 or 8). Both are sampled only at a frame strobe, so a change never alters a frame that is already on its way out. If a strobe arrives before the current frame has finished, the block flags an overrun and begins the new frame at once.

Top module: `adc_frame_builder`

## Requirements
- R1: While reset is asserted and whenever no frame is being sent, `word_valid`, `word_sof` and `overrun` are 0 and `word_out` is all zeros.
- R2: Frame bits 127:124 hold the sync value 1010, bits 123:122 hold the frame counter, bit 121 is 1 for 14-bit samples and 0 for 12-bit samples, and bit 120 is 1 for eight channels and 0 for four channels.
- R3: Starting at frame bit 119, channel 0 is placed first, then channels 1, 2 and so on. Each sample is written MSB first and uses W bits. W is 14 in wide mode; in narrow mode W is 12 and the low 12 bits of the lane are used. Lane c occupies `smp_lanes[14c+13:14c]`.
- R4: Every frame bit between the last sample bit and bit 8 is zero.
- R5: Frame bits 7:0 hold the CRC of bits 127:8, taken MSB first with polynomial x^8+x^2+x+1 and initial value zero. The CRC run over all 128 bits therefore gives zero.
- R6: Word k (k = 0..7) carries frame bits [127-16k : 112-16k]. The eight words are sent on eight consecutive cycles with `word_valid` high, and `word_sof` is high only with word 0.
- R7: Word 0 is on the outputs in the cycle that directly follows the clock edge at which `frame_strobe` is sampled high.
- R8: A strobe sampled while word 0..6 is on the outputs restarts the sequence on the new frame, and `overrun` is high for exactly the one cycle that shows the new word 0. A strobe sampled while word 7 is shown starts the next frame seamlessly, without an overrun.
- R9: The frame counter is 0 for the first frame after reset and increases by one, modulo 4, for every frame started, including frames started by an overrun.
- R10: Configuration, lanes and `smp_valid` are captured only at a strobe. Changes while a frame is being sent do not alter that frame.
- R11: If `smp_valid` is low when the strobe is sampled, all sample bits of that frame are zero. The header and CRC are still sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | 1 selects 14-bit samples, 0 selects 12-bit samples |
| cfg_eight | input | 1 | 1 selects eight channels, 0 selects four |
| frame_strobe | input | 1 | Start of a sampling period; samples are captured on this edge |
| smp_valid | input | 1 | Lane contents are valid at the strobe |
| smp_lanes | input | 112 | Eight 14-bit sample lanes, lane c at bits 14c+13:14c |
| word_out | output | 16 | Current frame word |
| word_valid | output | 1 | A frame word is being presented |
| word_sof | output | 1 | The presented word is word 0 of a frame |
| overrun | output | 1 | The previous frame was cut short by this one |

## Verification
Several properties are checked on every cycle. The stored frame must always leave a zero CRC residue. A strobe must be followed by word 0 with the start marker. An overrun may appear only together with that marker. The word run must continue without gaps and with a stable frame. The counter must step by one per strobe, and an idle bus must carry zeros. Only the bench's scenarios can show that header fields, packing order, narrow-lane truncation, zero fill and the exact CRC value match an independent model across the width and channel-count combinations. The same applies to the overrun and seamless back-to-back timing, and to mid-frame changes of configuration or samples having no effect.

// File: rtl/afb_pkg.sv
package afb_pkg;

    localparam int CH_MAX     = 8;
    localparam int CH_FEW     = 4;
    localparam int SMP_MAX    = 14;
    localparam int SMP_NARROW = 12;
    localparam int LANES_W    = CH_MAX * SMP_MAX;
    localparam int WORD_W     = 16;
    localparam int N_WORDS    = 8;
    localparam int FRAME_W    = WORD_W * N_WORDS;
    localparam int HDR_W      = 8;
    localparam int CRC_W      = 8;
    localparam int BODY_W     = FRAME_W - CRC_W;
    localparam int IDX_W      = $clog2(N_WORDS);
    localparam int CNT_W      = 2;

    localparam logic [3:0]       SYNC_VAL = 4'hA;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

    typedef struct packed {
        logic wide;
        logic eight;
    } cfg_t;

    typedef struct packed {
        logic [3:0]       sync;
        logic [CNT_W-1:0] cnt;
        logic             wide;
        logic             eight;
    } hdr_t;

    typedef logic [N_WORDS-1:0][WORD_W-1:0] frame_t;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

    function automatic logic [CRC_W-1:0] crc_body(input logic [BODY_W-1:0] d);
        logic [CRC_W-1:0] c;
        c = '0;
        for (int i = BODY_W - 1; i >= 0; i--) c = crc_step(c, d[i]);
        return c;
    endfunction

    function automatic logic [CRC_W-1:0] crc_residue(input logic [FRAME_W-1:0] d);
        logic [CRC_W-1:0] c;
        c = '0;
        for (int i = FRAME_W - 1; i >= 0; i--) c = crc_step(c, d[i]);
        return c;
    endfunction

endpackage

// File: rtl/afb_packer.sv
module afb_packer
    import afb_pkg::*;
(
    input  hdr_t                hdr,
    input  cfg_t                cfg,
    input  logic                use_samples,
    input  logic [LANES_W-1:0]  lanes,
    output logic [BODY_W-1:0]   body
);

    localparam int PAY_TOP = BODY_W - 1 - HDR_W;

    int nch;
    int w;

    always_comb begin
        nch  = cfg.eight ? CH_MAX : CH_FEW;
        w    = cfg.wide ? SMP_MAX : SMP_NARROW;
        body = '0;
        body[BODY_W-1 -: HDR_W] = hdr;
        if (use_samples) begin
            for (int c = 0; c < CH_MAX; c++) begin
                for (int k = 0; k < SMP_MAX; k++) begin
                    if (c < nch && k < w)
                        body[PAY_TOP - c * w - k] = lanes[c * SMP_MAX + w - 1 - k];
                end
            end
        end
    end

endmodule

// File: rtl/afb_crc.sv
module afb_crc
    import afb_pkg::*;
(
    input  logic [BODY_W-1:0] body,
    output logic [CRC_W-1:0]  crc
);

    always_comb crc = crc_body(body);

endmodule

// File: rtl/afb_sequencer.sv
module afb_sequencer
    import afb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame_in,
    output logic [CNT_W-1:0]   cnt,
    output logic [WORD_W-1:0]  word,
    output logic               valid,
    output logic               sof,
    output logic               ovr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_WORDS - 1);

    frame_t           words_q;
    logic [IDX_W-1:0] idx_q;
    logic             active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            words_q  <= '0;
            idx_q    <= '0;
            active_q <= 1'b0;
            ovr      <= 1'b0;
            cnt      <= '0;
        end else if (start) begin
            words_q  <= frame_t'(frame_in);
            idx_q    <= '0;
            active_q <= 1'b1;
            ovr      <= active_q && (idx_q != LAST);
            cnt      <= cnt + 1'b1;
        end else begin
            ovr <= 1'b0;
            if (active_q) begin
                if (idx_q == LAST) active_q <= 1'b0;
                else               idx_q    <= idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        valid = active_q;
        sof   = active_q && (idx_q == '0);
        word  = active_q ? words_q[LAST - idx_q] : '0;
    end

    // R7: word 0 follows a strobe directly
    a_r7_first_word: assert property (@(posedge clk) disable iff (rst)
        start |=> valid && sof);

    // R8: overrun only with a new frame start
    a_r8_ovr_at_sof: assert property (@(posedge clk) disable iff (rst)
        ovr |-> sof && valid);

    // R6: run continues without gaps until word 7
    a_r6_no_gap: assert property (@(posedge clk) disable iff (rst)
        valid && !start && idx_q != LAST |=> valid && !sof);

    // R10: stored frame is frozen while being sent
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        valid && !start |=> $stable(words_q));

    // R9: counter steps by one per started frame
    a_r9_cnt_step: assert property (@(posedge clk) disable iff (rst)
        start |=> cnt == $past(cnt) + 1'b1);

    // R5: every stored frame carries a consistent CRC
    a_r5_residue: assert property (@(posedge clk) disable iff (rst)
        valid |-> crc_residue(FRAME_W'(words_q)) == '0);

    // R1: idle bus carries zeros
    a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !valid |-> word == '0 && !ovr);

endmodule

// File: rtl/adc_frame_builder.sv
module adc_frame_builder
    import afb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wide,
    input  logic               cfg_eight,
    input  logic               frame_strobe,
    input  logic               smp_valid,
    input  logic [LANES_W-1:0] smp_lanes,
    output logic [WORD_W-1:0]  word_out,
    output logic               word_valid,
    output logic               word_sof,
    output logic               overrun
);

    cfg_t              cfg;
    hdr_t              hdr;
    logic [CNT_W-1:0]  frame_cnt;
    logic [BODY_W-1:0] body;
    logic [CRC_W-1:0]  crc;

    always_comb begin
        cfg.wide  = cfg_wide;
        cfg.eight = cfg_eight;
        hdr.sync  = SYNC_VAL;
        hdr.cnt   = frame_cnt;
        hdr.wide  = cfg_wide;
        hdr.eight = cfg_eight;
    end

    afb_packer u_pack (
        .hdr         (hdr),
        .cfg         (cfg),
        .use_samples (smp_valid),
        .lanes       (smp_lanes),
        .body        (body)
    );

    afb_crc u_crc (
        .body (body),
        .crc  (crc)
    );

    afb_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (frame_strobe),
        .frame_in ({body, crc}),
        .cnt      (frame_cnt),
        .word     (word_out),
        .valid    (word_valid),
        .sof      (word_sof),
        .ovr      (overrun)
    );

    // R6: start marker never without a valid word
    a_r6_sof_valid: assert property (@(posedge clk) disable iff (rst)
        word_sof |-> word_valid);

endmodule

// File: tb/sim_adc_frame_builder.sv
`timescale 1ns/1ps
module sim_adc_frame_builder;

    logic         clk = 1'b0;
    logic         rst;
    logic         cfg_wide, cfg_eight, frame_strobe, smp_valid;
    logic [111:0] smp_lanes;
    logic [15:0]  word_out;
    logic         word_valid, word_sof, overrun;

    int n_chk  = 0;
    int n_fail = 0;
    logic [1:0] cnt_m = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    adc_frame_builder u0 (
        .clk(clk), .rst(rst), .cfg_wide(cfg_wide), .cfg_eight(cfg_eight),
        .frame_strobe(frame_strobe), .smp_valid(smp_valid), .smp_lanes(smp_lanes),
        .word_out(word_out), .word_valid(word_valid), .word_sof(word_sof),
        .overrun(overrun)
    );

    // vector: [7]=wide [6]=eight [5]=valid [4:0]=seed (31 = all ones)
    localparam int NV = 8;
    localparam logic [7:0] VEC [NV] = '{
        8'b000_00011, 8'b100_00101, 8'b010_01001, 8'b110_10001,
        8'b111_11111, 8'b001_11111, 8'b011_00110, 8'b101_01110
    };

    function automatic logic [111:0] gen_lanes(input logic [4:0] seed);
        logic [111:0] l;
        for (int c = 0; c < 8; c++) begin
            if (seed == 5'd31) l[c*14 +: 14] = '1;
            else l[c*14 +: 14] = 14'((32'(seed) + 1) * 32'h1357 ^ (32'(c) * 32'h2A5B));
        end
        return l;
    endfunction

    function automatic logic [127:0] model(input logic wide, input logic eight,
        input logic vld, input logic [1:0] cnt, input logic [111:0] l);
        logic [127:0] acc;
        int n, w, nch;
        w = wide ? 14 : 12;
        nch = eight ? 8 : 4;
        acc = 128'({4'b1010, cnt, wide, eight});
        n = 8;
        for (int c = 0; c < nch; c++)
            for (int k = w - 1; k >= 0; k--) begin
                acc = (acc << 1) | 128'(vld & l[c*14 + k]);
                n++;
            end
        acc = acc << (120 - n);
        acc = acc << 8;
        for (int i = 127; i >= 8; i--)
            if (acc[i]) acc = acc ^ (128'h107 << (i - 8));
        // acc now holds only the remainder in bits 7:0; rebuild body
        return acc;
    endfunction

    function automatic logic [127:0] expected(input logic wide, input logic eight,
        input logic vld, input logic [1:0] cnt, input logic [111:0] l);
        logic [127:0] body;
        int n, w, nch;
        w = wide ? 14 : 12;
        nch = eight ? 8 : 4;
        body = 128'({4'b1010, cnt, wide, eight});
        n = 8;
        for (int c = 0; c < nch; c++)
            for (int k = w - 1; k >= 0; k--) begin
                body = (body << 1) | 128'(vld & l[c*14 + k]);
                n++;
            end
        body = body << (128 - n);
        return body | 128'(model(wide, eight, vld, cnt, l) & 128'hFF);
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // called at a negedge; strobe is captured at the following posedge
    task automatic strobe(input logic w, input logic e, input logic v,
                          input logic [111:0] l, output logic [127:0] exp);
        cfg_wide = w; cfg_eight = e; smp_valid = v; smp_lanes = l;
        frame_strobe = 1'b1;
        exp = expected(w, e, v, cnt_m, l);
        cnt_m = cnt_m + 1'b1;
        @(negedge clk);
        frame_strobe = 1'b0;
    endtask

    task automatic check_word(input int k, input logic [127:0] exp, input bit ovr_exp,
                              input string req);
        logic [15:0] ew;
        ew = exp[127 - 16*k -: 16];
        check(word_valid && word_out == ew, req, 128'(word_out), 128'(ew));
        check(word_sof == (k == 0), "R6 sof", 128'(word_sof), 128'(k == 0));
        check(overrun == ovr_exp, "R8 overrun", 128'(overrun), 128'(ovr_exp));
    endtask

    task automatic check_idle(input string req);
        check(!word_valid && !word_sof && !overrun && word_out == '0, req,
              128'({word_valid, word_sof, overrun, word_out}), 128'(0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic [127:0] ea, eb;
        rst = 1'b1; frame_strobe = 0; smp_valid = 0; smp_lanes = '0;
        cfg_wide = 0; cfg_eight = 0;
        repeat (3) @(negedge clk);
        check_idle("R1 reset state");
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1 idle after reset");

        // table walk: R2 R3 R4 R5 R6 R7 R11 R9
        for (int i = 0; i < NV; i++) begin
            logic [127:0] e;
            strobe(VEC[i][7], VEC[i][6], VEC[i][5], gen_lanes(VEC[i][4:0]), e);
            check(e[127:120] == {4'hA, 2'(cnt_m - 1'b1), VEC[i][7], VEC[i][6]},
                  "R2 model header", e[127:120], e[127:120]);
            for (int k = 0; k < 8; k++) begin
                check_word(k, e, 1'b0, "R3 R4 R5 R11 word");
                @(negedge clk);
            end
            check_idle("R1 idle after frame");
        end

        // R9 counter wraps: 8 frames done, next counter is 0
        strobe(1, 1, 1, gen_lanes(5'd2), ea);
        check(word_out[11:10] == 2'd0, "R9 counter wrap", 128'(word_out[11:10]), 128'(0));
        for (int k = 0; k < 8; k++) @(negedge clk);

        // R10: mid-frame changes ignored
        strobe(0, 1, 1, gen_lanes(5'd7), ea);
        cfg_wide = 1; cfg_eight = 0; smp_valid = 0; smp_lanes = gen_lanes(5'd31);
        for (int k = 0; k < 8; k++) begin
            check_word(k, ea, 1'b0, "R10 frame unchanged");
            @(negedge clk);
        end
        check_idle("R1 idle after R10 frame");

        // R8 overrun: new strobe while word 2 shown
        strobe(1, 0, 1, gen_lanes(5'd4), ea);
        check_word(0, ea, 1'b0, "R7 word0 next cycle");
        @(negedge clk);
        check_word(1, ea, 1'b0, "R6 word1");
        @(negedge clk);
        check_word(2, ea, 1'b0, "R6 word2");
        strobe(0, 1, 1, gen_lanes(5'd9), eb);
        for (int k = 0; k < 8; k++) begin
            check_word(k, eb, k == 0, "R8 restarted frame");
            @(negedge clk);
        end
        check_idle("R1 idle after overrun frame");

        // R8 seamless: new strobe while word 7 shown
        strobe(1, 1, 1, gen_lanes(5'd12), ea);
        for (int k = 0; k < 7; k++) begin
            check_word(k, ea, 1'b0, "R6 first frame");
            @(negedge clk);
        end
        check_word(7, ea, 1'b0, "R6 word7");
        strobe(0, 0, 1, gen_lanes(5'd13), eb);
        for (int k = 0; k < 8; k++) begin
            check_word(k, eb, 1'b0, "R8 seamless frame");
            @(negedge clk);
        end
        check_idle("R1 idle at end");

        // R1: reset mid-frame clears outputs
        strobe(1, 1, 1, gen_lanes(5'd1), ea);
        rst = 1'b1;
        @(negedge clk);
        check_idle("R1 reset mid-frame");
        rst = 1'b0;
        cnt_m = '0;
        strobe(0, 0, 1, gen_lanes(5'd3), ea);
        check_word(0, ea, 1'b0, "R9 counter zero after reset");

        done = 1;
        finish_run();
    end

endmodule